// File: doc/BRIEF.md
# Single-Match Set Intersection Finder

This block takes two lists of bytes, one of twenty entries and one of thirty, and finds the one value that appears in both. The lists arrive one byte per cycle over a load port. A select bit on that port says which list each byte belongs to, and the two lists may be interleaved in any order. The caller promises that the lists share at most one value. Under that promise the block never needs a result list, only one capture register.

Each byte is compared against every stored entry of the other list in the same cycle it is accepted. The answer is therefore final by the time the last byte has been stored. A one-cycle done pulse marks the completion of both lists. The result comes with a valid flag, so a shared value of zero can be told apart from no shared value. A sticky error flag records a broken promise or a surplus load. A synchronous clear prepares the block for the next pair of lists.

Top module: `set_isect_finder`

## Requirements
- R1: A load with `loadSel` = 0 goes to the first list, which takes 20 entries, and a load with `loadSel` = 1 goes to the second list, which takes 30 entries. The two lists may be loaded in any interleaving.
- R2: When an accepted byte equals an entry already stored in the other list, `resultData` shows that byte and `resultValid` is 1 from the cycle after that load onward.
- R3: Equal bytes within the same list are never reported as a match.
- R4: While no match has been found, `resultData` is 0 and `resultValid` is 0. A shared value of 0 is reported with `resultValid` = 1 and `resultData` = 0.
- R5: The first match is held. A later match leaves `resultData` unchanged and sets `protoErr`.
- R6: `done` is high for exactly one cycle, in the cycle after the load that brings the counts to 20 first-list and 30 second-list entries.
- R7: A load to a list that is already full is neither stored nor compared, and it sets `protoErr`.
- R8: A high `clearIn` empties both lists and resets the counts, the result, the valid flag and the error flag on the next edge. A load in the same cycle as the clear is discarded.
- R9: When `done` is high, `resultData` and `resultValid` already hold the final answer.
- R10: `protoErr` stays high until a clear or a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clearIn | input | 1 | Synchronous clear of lists, counts, result and flags |
| loadValid | input | 1 | A byte is offered this cycle |
| loadSel | input | 1 | 0 = first list, 1 = second list |
| loadData | input | 8 | Byte being loaded |
| resultData | output | 8 | Common value, or 0 when none has been found |
| resultValid | output | 1 | A common value has been captured |
| done | output | 1 | One-cycle pulse after both lists are complete |
| protoErr | output | 1 | Sticky: second match or load to a full list |

## Verification
The assertions assume that at most one load arrives per cycle and that a clear, once seen, restarts the whole exchange. They do not assume that the single-common-value promise holds. The held-result and sticky-error checks stay valid even when it is broken.

Most stimulus respects the promise, using value ranges that are disjoint except for a single planted byte. Two cases break it on purpose: one plants two common values, and one adds surplus loads after the lists are full. Another case drives a clear in the same cycle as a load.

// File: rtl/isect_pkg.sv
package isect_pkg;
  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic clr;   // wipe storage and result
    logic wrA;   // store loadData into first list
    logic wrB;   // store loadData into second list
  } isectStrb_t;
endpackage

// File: rtl/isect_ctrl.sv
module isect_ctrl
  import isect_pkg::*;
#(
  parameter int LEN_A = 20,
  parameter int LEN_B = 30,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clearIn,
  input  logic             loadValid,
  input  logic             loadSel,
  output isectStrb_t       strb,
  output logic [IDX_W-1:0] wrIdx,
  output logic             done,
  output logic             ovfErr
);
  localparam int CA_W = $clog2(LEN_A + 1);
  localparam int CB_W = $clog2(LEN_B + 1);

  logic [CA_W-1:0] cntA;
  logic [CB_W-1:0] cntB;
  logic            roomA, roomB, takeA, takeB, overflow;

  assign roomA    = (cntA != CA_W'(LEN_A));
  assign roomB    = (cntB != CB_W'(LEN_B));
  assign takeA    = !clearIn && loadValid && !loadSel && roomA;
  assign takeB    = !clearIn && loadValid &&  loadSel && roomB;
  assign overflow = !clearIn && loadValid && (loadSel ? !roomB : !roomA);

  assign strb.clr = clearIn;
  assign strb.wrA = takeA;
  assign strb.wrB = takeB;
  assign wrIdx    = loadSel ? IDX_W'(cntB) : IDX_W'(cntA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntA   <= '0;
      cntB   <= '0;
      done   <= 1'b0;
      ovfErr <= 1'b0;
    end else if (clearIn) begin
      cntA   <= '0;
      cntB   <= '0;
      done   <= 1'b0;
      ovfErr <= 1'b0;
    end else begin
      if (takeA) cntA <= cntA + 1'b1;
      if (takeB) cntB <= cntB + 1'b1;
      if (overflow) ovfErr <= 1'b1;
      done <= (takeA && cntA == CA_W'(LEN_A - 1) && cntB == CB_W'(LEN_B)) ||
              (takeB && cntB == CB_W'(LEN_B - 1) && cntA == CA_W'(LEN_A));
    end
  end

  // R1: counts never pass the list lengths
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cntA <= CA_W'(LEN_A)) && (cntB <= CB_W'(LEN_B)));

  // R6: done lasts a single cycle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: done only with both lists full
  assert_done_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cntA == CA_W'(LEN_A)) && (cntB == CB_W'(LEN_B)));

  // R7: a full list keeps its count
  assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cntA == CA_W'(LEN_A)) && !clearIn |=> (cntA == CA_W'(LEN_A)));

  // R10: overflow flag holds until clear
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovfErr && !clearIn |=> ovfErr);
endmodule

// File: rtl/isect_dpath.sv
module isect_dpath
  import isect_pkg::*;
#(
  parameter int LEN_A  = 20,
  parameter int LEN_B  = 30,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  isectStrb_t        strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] loadData,
  output logic [DATA_W-1:0] resultData,
  output logic              resultValid,
  output logic              dupErr
);
  logic [LEN_A-1:0] hitA;  // stored first-list entry equals loadData
  logic [LEN_B-1:0] hitB;  // stored second-list entry equals loadData
  logic             anyHit;

  genvar i;
  generate
    for (i = 0; i < LEN_A; i++) begin : g_listA
      logic [DATA_W-1:0] val;
      logic              vld;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val <= '0;
          vld <= 1'b0;
        end else if (strb.clr) begin
          vld <= 1'b0;
        end else if (strb.wrA && wrIdx == IDX_W'(i)) begin
          val <= loadData;
          vld <= 1'b1;
        end
      end
      assign hitA[i] = vld && (val == loadData);
    end
    for (i = 0; i < LEN_B; i++) begin : g_listB
      logic [DATA_W-1:0] val;
      logic              vld;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val <= '0;
          vld <= 1'b0;
        end else if (strb.clr) begin
          vld <= 1'b0;
        end else if (strb.wrB && wrIdx == IDX_W'(i)) begin
          val <= loadData;
          vld <= 1'b1;
        end
      end
      assign hitB[i] = vld && (val == loadData);
    end
  endgenerate

  // A byte is compared only with the opposite list
  assign anyHit = (strb.wrA && |hitB) || (strb.wrB && |hitA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resultData  <= '0;
      resultValid <= 1'b0;
      dupErr      <= 1'b0;
    end else if (strb.clr) begin
      resultData  <= '0;
      resultValid <= 1'b0;
      dupErr      <= 1'b0;
    end else if (anyHit) begin
      if (resultValid) begin
        dupErr <= 1'b1;
      end else begin
        resultData  <= loadData;
        resultValid <= 1'b1;
      end
    end
  end

  // R5: a captured value is held until clear
  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid && !strb.clr |=> resultValid && $stable(resultData));

  // R4: no value is shown without the valid flag
  assert_zero_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !resultValid |-> resultData == '0);

  // R8: clear empties the result
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clr |=> !resultValid && !dupErr);

  // R10: duplicate-match flag holds until clear
  assert_dup_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dupErr && !strb.clr |=> dupErr);

  // one write strobe at most per cycle
  assert_one_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.wrA && strb.wrB));
endmodule

// File: rtl/set_isect_finder.sv
module set_isect_finder
  import isect_pkg::*;
#(
  parameter int LEN_A  = 20,
  parameter int LEN_B  = 30,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clearIn,
  input  logic              loadValid,
  input  logic              loadSel,
  input  logic [DATA_W-1:0] loadData,
  output logic [DATA_W-1:0] resultData,
  output logic              resultValid,
  output logic              done,
  output logic              protoErr
);
  localparam int MAX_LEN = (LEN_A > LEN_B) ? LEN_A : LEN_B;
  localparam int IDX_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  isectStrb_t       strb;
  logic [IDX_W-1:0] wrIdx;
  logic             ovfErr, dupErr;

  isect_ctrl #(.LEN_A(LEN_A), .LEN_B(LEN_B), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clearIn(clearIn), .loadValid(loadValid),
    .loadSel(loadSel), .strb(strb), .wrIdx(wrIdx), .done(done), .ovfErr(ovfErr)
  );

  isect_dpath #(.LEN_A(LEN_A), .LEN_B(LEN_B), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrIdx(wrIdx), .loadData(loadData),
    .resultData(resultData), .resultValid(resultValid), .dupErr(dupErr)
  );

  assign protoErr = ovfErr || dupErr;
endmodule

// File: tb/set_isect_finder_tb.sv
module set_isect_finder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 20;
  localparam int NB = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clearIn = 1'b0;
  logic       loadValid = 1'b0;
  logic       loadSel = 1'b0;
  logic [7:0] loadData = '0;
  logic [7:0] resultData;
  logic       resultValid, done, protoErr;

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;
  string curTag = "R4";

  logic [7:0] aV [NA];
  logic [7:0] bV [NB];

  // reference model state
  logic [7:0] qa[$];
  logic [7:0] qb[$];
  logic [7:0] mData = '0;
  bit mValid = 0, mDone = 0, mErr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  set_isect_finder u_dut (
    .clk(clk), .rst_n(rst_n), .clearIn(clearIn), .loadValid(loadValid),
    .loadSel(loadSel), .loadData(loadData), .resultData(resultData),
    .resultValid(resultValid), .done(done), .protoErr(protoErr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    bit hit, took;
    hit = 0; took = 0;
    mDone = 0;
    if (!rst_n || clearIn) begin
      qa.delete(); qb.delete();
      mData = '0; mValid = 0; mErr = 0;
    end else if (loadValid) begin
      if (!loadSel) begin
        if (qa.size() < NA) begin
          foreach (qb[k]) if (qb[k] == loadData) hit = 1;
          qa.push_back(loadData); took = 1;
        end else mErr = 1;
      end else begin
        if (qb.size() < NB) begin
          foreach (qa[k]) if (qa[k] == loadData) hit = 1;
          qb.push_back(loadData); took = 1;
        end else mErr = 1;
      end
      if (hit) begin
        if (mValid) mErr = 1;
        else begin mValid = 1; mData = loadData; end
      end
      if (took && qa.size() == NA && qb.size() == NB) mDone = 1;
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(resultData == mData, {curTag, " resultData R2"}, resultData, mData);
      chk(resultValid == mValid, {curTag, " resultValid R4"}, resultValid, mValid);
      chk(done == mDone, {curTag, " done R6"}, done, mDone);
      chk(protoErr == mErr, {curTag, " protoErr R10"}, protoErr, mErr);
    end
  end

  task automatic push(input logic sel, input logic [7:0] d);
    loadValid = 1'b1; loadSel = sel; loadData = d;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doClear();
    clearIn = 1'b1;
    @(negedge clk);
    clearIn = 1'b0;
  endtask

  // mode 0: interleave, mode 1: second list first, mode 2: first list with gaps
  task automatic loadAll(input int mode);
    if (mode == 1) begin
      for (int j = 0; j < NB; j++) push(1'b1, bV[j]);
      for (int i = 0; i < NA; i++) push(1'b0, aV[i]);
    end else if (mode == 2) begin
      for (int i = 0; i < NA; i++) begin push(1'b0, aV[i]); if (i % 3 == 0) idle(1); end
      for (int j = 0; j < NB; j++) push(1'b1, bV[j]);
    end else begin
      for (int j = 0; j < NB; j++) begin
        if (j < NA) push(1'b0, aV[j]);
        push(1'b1, bV[j]);
      end
    end
  endtask

  task automatic fillDisjoint();
    for (int i = 0; i < NA; i++) aV[i] = 8'(10 + i);
    for (int j = 0; j < NB; j++) bV[j] = 8'(100 + j);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // reset state
    chk(resultValid == 0 && resultData == 0, "reset R4", resultValid, 0);
    chk(done == 0 && protoErr == 0, "reset R6", done, 0);

    // match planted mid-list, interleaved loading
    curTag = "R2";
    fillDisjoint(); aV[7] = 8'd55; bV[21] = 8'd55;
    loadAll(0);
    chk(done == 1, "last load R6", done, 1);
    chk(resultValid == 1 && resultData == 8'd55, "final at done R9", resultData, 55);
    idle(1);
    chk(done == 0, "single pulse R6", done, 0);
    doClear();

    // no match, second list first
    curTag = "R4";
    fillDisjoint();
    loadAll(1);
    chk(resultValid == 0 && resultData == 0, "no match R4", resultValid, 0);
    doClear();

    // common value zero, first list with gaps
    curTag = "R1";
    fillDisjoint(); aV[19] = 8'd0; bV[0] = 8'd0;
    loadAll(2);
    chk(resultValid == 1 && resultData == 0, "zero match R4", resultValid, 1);
    doClear();

    // duplicates inside one list only
    curTag = "R3";
    fillDisjoint(); aV[2] = 8'd7; aV[12] = 8'd7; bV[4] = 8'd9; bV[25] = 8'd9;
    loadAll(0);
    chk(resultValid == 0, "same-list dup R3", resultValid, 0);
    chk(protoErr == 0, "same-list dup err R3", protoErr, 0);
    doClear();

    // two common values: first held, error raised
    curTag = "R5";
    fillDisjoint(); aV[0] = 8'd200; bV[0] = 8'd200; aV[1] = 8'd201; bV[1] = 8'd201;
    loadAll(0);
    chk(resultData == 8'd200, "first match held R5", resultData, 200);
    chk(protoErr == 1, "second match err R5", protoErr, 1);
    idle(3);
    chk(protoErr == 1, "err sticky R10", protoErr, 1);
    doClear();

    // surplus loads after both lists are full
    curTag = "R7";
    fillDisjoint();
    loadAll(0);
    push(1'b0, 8'd100);
    chk(resultValid == 0, "extra load not compared R7", resultValid, 0);
    chk(protoErr == 1 && done == 0, "extra load err R7", protoErr, 1);
    push(1'b1, 8'd10);
    chk(resultValid == 0, "extra second-list load R7", resultValid, 0);

    // clear together with a load
    curTag = "R8";
    clearIn = 1'b1; loadValid = 1'b1; loadSel = 1'b0; loadData = 8'd42;
    @(negedge clk);
    clearIn = 1'b0; loadValid = 1'b0;
    chk(protoErr == 0 && resultValid == 0, "clear wipes R8", protoErr, 0);
    fillDisjoint(); bV[3] = 8'd42;
    loadAll(1);
    chk(resultValid == 0, "load under clear dropped R8", resultValid, 0);
    chk(done == 1, "counts restarted R8", done, 1);
    idle(2);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule